// File: doc/BRIEF.md
# Pulse-Pair Doppler Accumulator

This block takes a stream of complex baseband samples arranged as successive radar pulses, each pulse split into K range gates, one sample per gate. Over a batch of N pulses it builds two sums for every range gate. The first is the power sum, the accumulated squared magnitude of the gate's samples. The second is the lag-one correlation sum: each sample times the complex conjugate of the sample the same gate held in the previous pulse. The phase of the averaged correlation gives how far the echo moved between pulses, and its magnitude shows how much weight that phase deserves.

Three K-entry stores, each addressed by range gate, hold the state. One keeps the previous pulse's sample. One keeps the complex correlation sums and one keeps the power sums, so a gate's sums are read, updated and written back as that gate's new sample passes. A start-of-pulse flag on the input restarts the gate count and advances the pulse count. During the last pulse of each batch the block emits, gate by gate, both sums scaled down by N with an arithmetic right shift. The first pulse of the next batch overwrites the sums, so no separate clearing pass is needed.

Top module: `pulse_pair_acc`

## Requirements
- R1: While reset is held, and on the cycle after it is released, out_valid is 0 and out_gate, out_dop_re, out_dop_im and out_pwr are 0.
- R2: A valid sample with in_sop=1 is gate 0. Each further valid sample with in_sop=0 is the next gate. The pulse index is 0 at the first in_sop after reset and then counts in_sop flags modulo N=2^N_LOG2. Valid samples that arrive before the first in_sop after reset are ignored.
- R3: In a pulse longer than K_GATES samples, the samples after gate K_GATES-1 are ignored. They leave the stored state unchanged and produce no output.
- R4: The power output for a gate is the sum over pulses 0..N-1 of I*I+Q*Q, arithmetically right-shifted by N_LOG2.
- R5: The Doppler output for a gate is the sum over pulses 1..N-1 of s*conj(p), where p is the same gate's sample from the previous pulse: real = I*Ip+Q*Qp, imaginary = Q*Ip-I*Qp. Each part is arithmetically right-shifted by N_LOG2. Pulse 0 of a batch adds no product.
- R6: When a sample of pulse N-1 for gate g is accepted on a clock edge, out_valid is 1 for the following cycle, with out_gate=g and that gate's results. At every other time out_valid is 0.
- R7: Each batch's results depend only on that batch's samples. Pulse 0 restarts both sums of its gate, although the previous-pulse sample it uses for the next pulse is still stored.
- R8: A cycle with in_valid=0 changes nothing, whatever in_sop, in_i and in_q carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sop | input | 1 | Marks the first gate of a pulse |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_valid | output | 1 | Result strobe for one gate |
| out_gate | output | $clog2(K_GATES) | Range gate of the result |
| out_dop_re | output | 2*DW+1+N_LOG2 | Averaged correlation, real part, signed |
| out_dop_im | output | 2*DW+1+N_LOG2 | Averaged correlation, imaginary part, signed |
| out_pwr | output | 2*DW+1+N_LOG2 | Averaged power, signed |

## Verification
The bench runs several full batches over a four-gate, four-pulse configuration and compares every gate's outputs with sums it computes itself. The batches include full-scale negative samples. If a design dropped a product bit or the sign extension, those samples would give wrong extreme sums, and a design that used a logical shift would turn negative correlations into huge positive values. Idle cycles that carry junk in_sop and data flags catch a design that acts on unqualified inputs. Samples sent before the first pulse marker, and an extra sample at the end of an over-long pulse, catch a design that stores them: a stray write wraps onto gate 0 and corrupts its sums in the next batch. Back-to-back batches catch a design that keeps stale correlation sums or multiplies against the previous batch's last pulse on pulse 0.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Position of the current pulse within its averaging batch.
  typedef struct packed {
    logic first;
    logic last;
  } batch_pos_t;
endpackage

// File: rtl/pp_gate_store.sv
// One entry per range gate, combinational read, write on the accepting edge.
module pp_gate_store #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/pp_arith.sv
// Conjugate lag product and squared magnitude of one complex sample.
module pp_arith #(
  parameter int DW = 12,
  localparam int PW = 2*DW+1
) (
  input  logic signed [DW-1:0] cur_i,
  input  logic signed [DW-1:0] cur_q,
  input  logic signed [DW-1:0] prv_i,
  input  logic signed [DW-1:0] prv_q,
  output logic signed [PW-1:0] lag_re,
  output logic signed [PW-1:0] lag_im,
  output logic signed [PW-1:0] mag2
);
  function automatic logic signed [PW-1:0] mac2(
    input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
    input logic signed [DW-1:0] c, input logic signed [DW-1:0] d,
    input logic subtract);
    logic signed [PW-1:0] p0, p1;
    p0 = PW'(a) * PW'(b);
    p1 = PW'(c) * PW'(d);
    return subtract ? p0 - p1 : p0 + p1;
  endfunction

  // s * conj(p) = (I*Ip + Q*Qp) + j(Q*Ip - I*Qp)
  assign lag_re = mac2(cur_i, prv_i, cur_q, prv_q, 1'b0);
  assign lag_im = mac2(cur_q, prv_i, cur_i, prv_q, 1'b1);
  assign mag2   = mac2(cur_i, cur_i, cur_q, cur_q, 1'b0);
endmodule

// File: rtl/pulse_pair_acc.sv
module pulse_pair_acc #(
  parameter int K_GATES = 16,
  parameter int N_LOG2 = 3,
  parameter int DW = 12,
  localparam int AW = $clog2(K_GATES),
  localparam int GW = AW + 1,
  localparam int PW = 2*DW + 1,
  localparam int ACC_W = PW + N_LOG2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sop,
  input  logic signed [DW-1:0]    in_i,
  input  logic signed [DW-1:0]    in_q,
  output logic                    out_valid,
  output logic [AW-1:0]           out_gate,
  output logic signed [ACC_W-1:0] out_dop_re,
  output logic signed [ACC_W-1:0] out_dop_im,
  output logic signed [ACC_W-1:0] out_pwr
);
  import pp_pkg::*;

  // Framing state
  logic              started_q;
  logic [GW-1:0]     gate_q;
  logic [N_LOG2-1:0] pulse_q;

  // Named events, also observed by the checker
  logic              framed;
  logic              sample_take;
  logic [GW-1:0]     gate_nx;
  logic [N_LOG2-1:0] pulse_nx;
  batch_pos_t        pos;
  logic [AW-1:0]     addr;

  assign framed = in_valid && (in_sop || started_q);

  always_comb begin
    if (in_sop)                         gate_nx = '0;
    else if (gate_q >= GW'(K_GATES))    gate_nx = GW'(K_GATES);
    else                                gate_nx = gate_q + 1'b1;
  end

  assign pulse_nx    = in_sop ? (started_q ? pulse_q + 1'b1 : '0) : pulse_q;
  assign sample_take = framed && (gate_nx < GW'(K_GATES));
  assign pos.first   = (pulse_nx == '0);
  assign pos.last    = &pulse_nx;
  assign addr        = gate_nx[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      gate_q    <= '0;
      pulse_q   <= '0;
    end else if (framed) begin
      started_q <= 1'b1;
      gate_q    <= gate_nx;
      pulse_q   <= pulse_nx;
    end
  end

  // Per-gate storage
  logic [2*DW-1:0]    prev_word;
  logic [2*ACC_W-1:0] dop_word, dop_wr;
  logic [ACC_W-1:0]   pwr_word;

  pp_gate_store #(.W(2*DW), .DEPTH(K_GATES)) prev_store_i (
    .clk(clk), .rst_n(rst_n), .we(sample_take), .addr(addr),
    .wdata({in_i, in_q}), .rdata(prev_word));

  pp_gate_store #(.W(2*ACC_W), .DEPTH(K_GATES)) dop_store_i (
    .clk(clk), .rst_n(rst_n), .we(sample_take), .addr(addr),
    .wdata(dop_wr), .rdata(dop_word));

  logic signed [ACC_W-1:0] pwr_new;

  pp_gate_store #(.W(ACC_W), .DEPTH(K_GATES)) pwr_store_i (
    .clk(clk), .rst_n(rst_n), .we(sample_take), .addr(addr),
    .wdata(pwr_new), .rdata(pwr_word));

  // Arithmetic
  logic signed [DW-1:0] prv_i, prv_q;
  logic signed [PW-1:0] lag_re, lag_im, mag2;

  assign prv_i = prev_word[2*DW-1:DW];
  assign prv_q = prev_word[DW-1:0];

  pp_arith #(.DW(DW)) arith_i (
    .cur_i(in_i), .cur_q(in_q), .prv_i(prv_i), .prv_q(prv_q),
    .lag_re(lag_re), .lag_im(lag_im), .mag2(mag2));

  logic signed [ACC_W-1:0] dop_old_re, dop_old_im, pwr_old;
  logic signed [ACC_W-1:0] dop_new_re, dop_new_im;

  assign dop_old_re = dop_word[2*ACC_W-1:ACC_W];
  assign dop_old_im = dop_word[ACC_W-1:0];
  assign pwr_old    = pwr_word;

  // Pulse 0 restarts the sums: power takes its first term, Doppler holds zero.
  assign pwr_new    = (pos.first ? '0 : pwr_old) + ACC_W'(mag2);
  assign dop_new_re = pos.first ? '0 : dop_old_re + ACC_W'(lag_re);
  assign dop_new_im = pos.first ? '0 : dop_old_im + ACC_W'(lag_im);
  assign dop_wr     = {dop_new_re, dop_new_im};

  // Result register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_gate   <= '0;
      out_dop_re <= '0;
      out_dop_im <= '0;
      out_pwr    <= '0;
    end else begin
      out_valid <= sample_take && pos.last;
      if (sample_take && pos.last) begin
        out_gate   <= addr;
        out_dop_re <= dop_new_re >>> N_LOG2;
        out_dop_im <= dop_new_im >>> N_LOG2;
        out_pwr    <= pwr_new >>> N_LOG2;
      end
    end
  end
endmodule

// File: rtl/pp_acc_checks.sv
module pp_acc_checks #(
  parameter int K_GATES = 16,
  parameter int N_LOG2 = 3,
  parameter int DW = 12,
  localparam int AW = $clog2(K_GATES),
  localparam int ACC_W = 2*DW + 1 + N_LOG2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             framed,
  input logic             sample_take,
  input logic             first_pulse,
  input logic             out_valid,
  input logic [AW-1:0]    out_gate,
  input logic [ACC_W-1:0] out_pwr
);
  assert_out_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_no_out_after_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_take && first_pulse) |=> !out_valid);

  assert_pwr_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_pwr[ACC_W-1]);

  assert_gate_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_gate == AW'($past(out_gate) + 1'b1)));

  assert_overlength_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (framed && !sample_take) |=> !out_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

bind pulse_pair_acc pp_acc_checks #(.K_GATES(K_GATES), .N_LOG2(N_LOG2), .DW(DW)) checks_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .framed(framed),
  .sample_take(sample_take), .first_pulse(pos.first), .out_valid(out_valid),
  .out_gate(out_gate), .out_pwr(out_pwr));

// File: tb/pulse_pair_acc_tb_top.sv
module pulse_pair_acc_tb_top;
  localparam int K = 4;
  localparam int NL = 2;
  localparam int N = 1 << NL;
  localparam int DW = 8;
  localparam int AW = $clog2(K);
  localparam int ACC_W = 2*DW + 1 + NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sop = 1'b0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic out_valid;
  logic [AW-1:0] out_gate;
  logic signed [ACC_W-1:0] out_dop_re, out_dop_im, out_pwr;

  always #10 clk = ~clk;

  pulse_pair_acc #(.K_GATES(K), .N_LOG2(NL), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_gate(out_gate),
    .out_dop_re(out_dop_re), .out_dop_im(out_dop_im), .out_pwr(out_pwr));

  int n_chk = 0;
  int n_bad = 0;

  // Reference state, kept from the requirements
  bit     m_started = 0;
  int     m_gate = 0;
  int     m_pulse = 0;
  longint m_pi [K];
  longint m_pq [K];
  longint m_pwr [K];
  longint m_dre [K];
  longint m_dim [K];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one valid sample at a falling edge; check the outputs one edge later.
  task automatic send(input int i, input int q, input bit sop, input string tag);
    bit exp_v = 0;
    int eg = 0;
    longint e_re = 0, e_im = 0, e_pw = 0;
    in_valid = 1'b1; in_sop = sop; in_i = DW'(i); in_q = DW'(q);
    if (sop || m_started) begin
      eg = sop ? 0 : ((m_gate >= K) ? K : m_gate + 1);
      m_pulse = sop ? (m_started ? (m_pulse + 1) % N : 0) : m_pulse;
      m_started = 1; m_gate = eg;
      if (eg < K) begin
        if (m_pulse == 0) begin
          m_pwr[eg] = longint'(i)*i + longint'(q)*q;
          m_dre[eg] = 0; m_dim[eg] = 0;
        end else begin
          m_pwr[eg] += longint'(i)*i + longint'(q)*q;
          m_dre[eg] += longint'(i)*m_pi[eg] + longint'(q)*m_pq[eg];
          m_dim[eg] += longint'(q)*m_pi[eg] - longint'(i)*m_pq[eg];
        end
        m_pi[eg] = i; m_pq[eg] = q;
        if (m_pulse == N-1) begin
          exp_v = 1;
          e_re = m_dre[eg] >>> NL; e_im = m_dim[eg] >>> NL; e_pw = m_pwr[eg] >>> NL;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == exp_v, {tag, " R6 out_valid"}, out_valid, exp_v);
    if (exp_v && out_valid) begin
      check(out_gate == AW'(eg), {tag, " R2 gate"}, out_gate, eg);
      check(longint'(out_pwr) == e_pw, {tag, " R4 R7 power"}, out_pwr, e_pw);
      check(longint'(out_dop_re) == e_re, {tag, " R5 R7 doppler re"}, out_dop_re, e_re);
      check(longint'(out_dop_im) == e_im, {tag, " R5 R7 doppler im"}, out_dop_im, e_im);
    end
  endtask

  // Idle cycle with junk on the unqualified inputs
  task automatic idle(input int seed);
    in_valid = 1'b0; in_sop = seed[0]; in_i = DW'(seed * 29); in_q = DW'(seed * 53);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle cycle", out_valid, 0);
    in_sop = 1'b0;
  endtask

  function automatic int gen(input int b, input int p, input int g, input int c);
    case (b)
      0: return (c == 0) ? (g + 1) * (p + 1) : -(g + 2 * p);
      3: return -128;
      4: return ((p + g + c) % 2 == 0) ? 127 : -128;
      default: return ((b * 37 + p * 11 + g * 5 + c * 3 + 7) * 73) % 256 - 128;
    endcase
  endfunction

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < K; k++) begin
      m_pi[k] = 0; m_pq[k] = 0; m_pwr[k] = 0; m_dre[k] = 0; m_dim[k] = 0;
    end
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0, "R1 after reset out_valid", out_valid, 0);
    check(out_pwr == 0 && out_dop_re == 0 && out_dop_im == 0 && out_gate == 0,
          "R1 after reset data", out_pwr, 0);

    // Samples before any pulse marker are ignored
    for (int j = 0; j < 3; j++) send(100 + j, -90, 1'b0, "R2 pre-sop");

    for (int b = 0; b < 6; b++) begin
      for (int p = 0; p < N; p++) begin
        for (int g = 0; g < K; g++) begin
          send(gen(b, p, g, 0), gen(b, p, g, 1), g == 0, "batch");
          if (b == 1 && g == 1) idle(b + p + g);
        end
        // Over-length pulse: an extra sample past the last gate
        if (b == 2 || b == 5) send(127, -128, 1'b0, "R3 overlength");
        if (b == 4) idle(p);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule